// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the serial clock for a synchronous serial shift engine from the system clock. The divide ratio is split across two cascaded counters. The first stage counts half of an even prescale value, and the second stage counts the first stage's wraps up to a post value plus one. The serial clock therefore toggles every (prescale/2)·(post+1) system clocks. This gives a full period of prescale·(post+1) clocks at a 50% duty cycle.

The two 8-bit setting fields arrive from the controller's configuration word. Upstream wiring takes the prescale field from bits 11:4 and the post field from bits 19:12. Illegal prescale settings are clamped: values below 2 become 2, and odd values lose their least significant bit. The block latches its settings only while `run` is low and holds them for the whole of a run. While idle, both counters are held at their reload value, so the first edge after a start always comes one full half period later.

Besides the serial clock level, the block gives the shift engine a half-period tick and separate rising and falling edge strobes. Each strobe is high for exactly the one system clock that precedes the matching serial clock edge.

Top module: `spi_sck_divider`

## Requirements
- R1: With legal settings P (even, 2..254) and Q (0..255), the serial clock toggles every H = (P/2)·(Q+1) system clocks, giving a full period of P·(Q+1) clocks at 50% duty.
- R2: A prescale setting of 0 or 1 behaves exactly like a setting of 2.
- R3: An odd prescale setting of 3 or more behaves like that value with bit 0 cleared (7 acts as 6, 255 acts as 254).
- R4: The post setting uses its full range 0..255. The largest ratio, with prescale 254 or 255 and post 255, gives a half period of 32512 clocks (period 65024).
- R5: While `run` is low, `sck` is 0 and `half_tick`, `rise_stb` and `fall_stb` stay 0, even when the settings change.
- R6: After `run` is first sampled high at a clock edge, `sck` rises at the H-th edge that samples `run` high.
- R7: `rise_stb` is 1 only during the clock cycle just before an `sck` 0→1 edge, and `fall_stb` is 1 only during the cycle just before a 1→0 edge. `half_tick` is 1 in both of those cycles.
- R8: Settings are captured only on edges where `run` is low. Changes made while `run` is high do not alter the half period until `run` has been low for at least one edge.
- R9: During and right after reset, `sck` is 0 and all strobes are 0.
- R10: Dropping `run` forces `sck` to 0 at the next edge. A later restart again waits a full half period of the newly captured settings before the first rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High while the serial clock should run; low holds and reloads |
| cfg_prescale | input | 8 | Raw prescale setting (clamped to an even value 2..254) |
| cfg_post | input | 8 | Post-divide setting; second stage divides by this plus one |
| sck | output | 1 | Serial clock level, idle low |
| half_tick | output | 1 | One-cycle pulse before every serial clock toggle |
| rise_stb | output | 1 | One-cycle pulse before each rising serial clock edge |
| fall_stb | output | 1 | One-cycle pulse before each falling serial clock edge |

## Verification
A corrupted prescale or post counter, or a wrongly clamped or latched setting, appears at the `sck` pin as a half period of the wrong length. It therefore shows up no later than the first toggle after a start, which is at most one half period (32512 clocks in the worst case). A toggle flop out of step with the strobes shows up within one cycle as a strobe of the wrong kind before an edge, or as a strobe count other than one per half period. Capture faults during a run are exposed by changing the settings mid-run and timing the next half periods, then restarting and timing against the new settings.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

  // width of each raw divider setting field
  localparam int FW = 8;
  // width of the halved prescale value (2..254 -> 1..127)
  localparam int PW = FW - 1;
  // width that holds a half period in system clocks
  localparam int HW = 2 * FW;
  // smallest legal prescale value
  localparam logic [FW-1:0] PRE_FLOOR = FW'(2);

  // Clamp a raw prescale setting to an even value no smaller than the floor.
  function automatic logic [FW-1:0] legal_pre(input logic [FW-1:0] raw);
    logic [FW-1:0] v;
    if (raw < PRE_FLOOR) v = PRE_FLOOR;
    else                 v = {raw[FW-1:1], 1'b0};
    return v;
  endfunction

  // Half of the clamped prescale: the first-stage count length.
  function automatic logic [PW-1:0] pre_half(input logic [FW-1:0] raw);
    logic [FW-1:0] v;
    v = legal_pre(raw);
    return v[FW-1:1];
  endfunction

  // Half period in system clocks from first-stage length and post value.
  function automatic logic [HW-1:0] span_cycles(input logic [PW-1:0] half_pre,
                                                input logic [FW-1:0] post);
    logic [HW-1:0] a;
    logic [HW-1:0] b;
    a = HW'(half_pre);
    b = HW'(post) + HW'(1);
    return a * b;
  endfunction

endpackage

// File: rtl/div_cfg_latch.sv
module div_cfg_latch
  import spi_div_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [FW-1:0] pre_raw,
  input  logic [FW-1:0] post_raw,
  output logic [PW-1:0] half_pre_q,
  output logic [FW-1:0] post_q
);

  // Settings follow the inputs only while idle and freeze during a run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_pre_q <= PW'(1);
      post_q     <= '0;
    end else if (!run) begin
      half_pre_q <= pre_half(pre_raw);
      post_q     <= post_raw;
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(half_pre_q) && $stable(post_q)));

endmodule

// File: rtl/div_prescale_stage.sv
module div_prescale_stage
  import spi_div_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] lim,
  output logic          wrap
);

  logic [PW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == (lim - PW'(1)));
  assign wrap   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (at_end)    cnt_q <= '0;
    else                cnt_q <= cnt_q + PW'(1);
  end

  // R1
  pre_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim);

  // R5
  pre_idle_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/div_post_stage.sv
module div_post_stage
  import spi_div_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [FW-1:0] lim,
  output logic          wrap
);

  logic [FW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == lim);
  assign wrap   = run && step && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (step) begin
      if (at_end)      cnt_q <= '0;
      else             cnt_q <= cnt_q + FW'(1);
    end
  end

  // R4
  post_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic sck,
  output logic rise,
  output logic fall
);

  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sck_q <= 1'b0;
    else if (!run)   sck_q <= 1'b0;
    else if (tick)   sck_q <= ~sck_q;
  end

  assign sck  = sck_q;
  assign rise = tick & ~sck_q;
  assign fall = tick &  sck_q;

  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);

  // R7
  rise_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && run) |=> sck);

  // R7
  fall_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !sck);

  // R1
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sck));

endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import spi_div_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [FW-1:0] cfg_prescale,
  input  logic [FW-1:0] cfg_post,
  output logic          sck,
  output logic          half_tick,
  output logic          rise_stb,
  output logic          fall_stb
);

  // named internal events
  logic [PW-1:0] half_pre;
  logic [FW-1:0] post_lim;
  logic          pre_wrap;
  logic          post_wrap;

  div_cfg_latch u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .pre_raw   (cfg_prescale),
    .post_raw  (cfg_post),
    .half_pre_q(half_pre),
    .post_q    (post_lim)
  );

  div_prescale_stage u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .lim  (half_pre),
    .wrap (pre_wrap)
  );

  div_post_stage u_post (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .step (pre_wrap),
    .lim  (post_lim),
    .wrap (post_wrap)
  );

  sck_edge_gen u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (post_wrap),
    .sck  (sck),
    .rise (rise_stb),
    .fall (fall_stb)
  );

  assign half_tick = post_wrap;

  // Cycles since the last toggle or start, observed by the spacing check.
  logic [HW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap_q <= '0;
    else if (!run || post_wrap)  gap_q <= '0;
    else                         gap_q <= gap_q + HW'(1);
  end

  // R1
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_wrap |-> (gap_q == span_cycles(half_pre, post_lim) - HW'(1)));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));

  // R9
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> run);

endmodule

// File: tb/test_spi_sck_divider.sv
`timescale 1ns/1ps
module test_spi_sck_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] cfg_prescale = 8'd2;
  logic [7:0] cfg_post = 8'd0;
  logic       sck, half_tick, rise_stb, fall_stb;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_sck_divider i_spi_sck_divider (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .cfg_prescale(cfg_prescale),
    .cfg_post    (cfg_post),
    .sck         (sck),
    .half_tick   (half_tick),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb)
  );

  // {prescale, post, expected half period}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {8'd2,   8'd0,   16'd1},      // R1 smallest ratio
    {8'd4,   8'd0,   16'd2},      // R1
    {8'd10,  8'd4,   16'd25},     // R1
    {8'd0,   8'd0,   16'd1},      // R2 zero acts as 2
    {8'd1,   8'd3,   16'd4},      // R2 one acts as 2
    {8'd7,   8'd2,   16'd9},      // R3 7 acts as 6
    {8'd255, 8'd1,   16'd254},    // R3 255 acts as 254
    {8'd6,   8'd255, 16'd768},    // R4 full post range
    {8'd254, 8'd255, 16'd32512}   // R4 largest ratio
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entered just after a negedge; counts edges until sck reaches lvl.
  task automatic measure(input logic lvl, input int exp, input string req);
    int n;
    int st;
    int ht;
    n = 0; st = 0; ht = 0;
    do begin
      #1;
      if (lvl ? rise_stb : fall_stb) st++;
      if (half_tick) ht++;
      @(posedge clk); #1;
      n++;
      @(negedge clk);
    end while (sck !== lvl && n < 70000);
    check(n == exp, req, n, exp);
    check(st == 1, {req, " R7 edge strobe count"}, st, 1);
    check(ht == 1, {req, " R7 tick count"}, ht, 1);
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check(sck == 1'b0 && half_tick == 1'b0 && rise_stb == 1'b0 && fall_stb == 1'b0,
          "R9 in reset", {sck, half_tick, rise_stb, fall_stb}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sck == 1'b0 && half_tick == 1'b0, "R9 after reset", {sck, half_tick}, 0);

    // table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      run = 1'b0;
      cfg_prescale = VEC[i][31:24];
      cfg_post = VEC[i][23:16];
      repeat (2) @(negedge clk);
      check(sck == 1'b0, "R5 idle level", sck, 0);
      run = 1'b1;
      measure(1'b1, int'(VEC[i][15:0]), "R6 first rise");
      measure(1'b0, int'(VEC[i][15:0]), "R1 high time");
    end

    // R8: mid-run changes are ignored
    run = 1'b0;
    cfg_prescale = 8'd4;
    cfg_post = 8'd0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    measure(1'b1, 2, "R8 baseline rise");
    cfg_prescale = 8'd20;
    cfg_post = 8'd1;
    measure(1'b0, 2, "R8 change held off");
    measure(1'b1, 2, "R8 change still held off");

    // R10: dropping run clears sck at the next edge
    run = 1'b0;
    @(posedge clk); #1;
    check(sck == 1'b0, "R10 sck cleared", sck, 0);
    // R5: no activity while idle, even with settings toggling
    begin
      int act;
      act = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        cfg_prescale = (k % 2 == 0) ? 8'd2 : 8'd20;
        #1;
        if (half_tick || rise_stb || fall_stb || sck) act++;
      end
      check(act == 0, "R5 idle quiet", act, 0);
    end
    // R10 / R8: restart uses the newly captured settings, 10 * 2 = 20
    @(negedge clk);
    cfg_prescale = 8'd20;
    cfg_post = 8'd1;
    repeat (2) @(negedge clk);
    run = 1'b1;
    measure(1'b1, 20, "R10 restart rise");
    measure(1'b0, 20, "R10 restart high time");

    run = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule